// File: doc/BRIEF.md
# Accumulator with Bit-Sliced Adder and Logic Stage

This block holds a 16-bit accumulator together with a one-bit link flip-flop that catches the carry of an addition and feeds the rotate operations. A decoder outside the block asserts at most one operation strobe per cycle. On the next rising clock edge the accumulator and the link bit take the result of that operation. The possible operations are a bitwise AND with the data operand, a two's-complement add, a plain load of the operand, a load of the low byte from an 8-bit input port, a complement, a rotate right or left through the link bit, a clear, and an increment.

Internally every strobe becomes one of three register controls. Clear and increment act on the register directly. All the other operations load the output of a column of identical bit stages. Each stage holds a full adder and an AND-OR selector that picks among AND, sum, operand bit, input-port bit, inverted bit and the neighbouring bits.

Top module: `accum_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `acc_q` becomes 0x0000 and `link_q` becomes 0.
- R2: `do_and` sets `acc_q` to the previous `acc_q` AND `data_in`, and `link_q` is unchanged.
- R3: `do_add` sets `acc_q` to the low 16 bits of the previous `acc_q` plus `data_in`, and `link_q` to the carry out of bit 15.
- R4: `do_load` copies `data_in` into `acc_q`, and `link_q` is unchanged.
- R5: `do_input` writes `port_in` into `acc_q[7:0]`. `acc_q[15:8]` and `link_q` are unchanged.
- R6: `do_comp` replaces `acc_q` with its bitwise inverse, and `link_q` is unchanged.
- R7: `do_shr` moves every bit of `acc_q` one place toward bit 0. The old `link_q` enters bit 15 and the old bit 0 goes to `link_q`.
- R8: `do_shl` moves every bit of `acc_q` one place toward bit 15. The old `link_q` enters bit 0 and the old bit 15 goes to `link_q`.
- R9: `do_clr` sets `acc_q` to 0x0000, and `link_q` is unchanged.
- R10: `do_inc` adds one to `acc_q`, so 0xFFFF becomes 0x0000, and `link_q` is unchanged. The increment never sets `link_q`.
- R11: With no strobe high, `acc_q` and `link_q` hold their values.
- R12: Each result appears on `acc_q`/`link_q` right after the single clock edge at which its strobe is sampled. At most one strobe may be high per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 16 | Operand word |
| port_in | input | 8 | Input-port byte |
| do_and | input | 1 | AND strobe |
| do_add | input | 1 | Add strobe |
| do_load | input | 1 | Load-operand strobe |
| do_input | input | 1 | Load-low-byte strobe |
| do_comp | input | 1 | Complement strobe |
| do_shr | input | 1 | Rotate-right strobe |
| do_shl | input | 1 | Rotate-left strobe |
| do_clr | input | 1 | Clear strobe |
| do_inc | input | 1 | Increment strobe |
| acc_q | output | 16 | Accumulator value |
| link_q | output | 1 | Link (carry) bit |

## Verification
The bench drives the add with operands whose sum carries out of bit 15 and with sums that land exactly on 0xFFFF. A broken carry chain or a wrong link capture shows up there as a wrong high bit or a stale link. It increments 0xFFFF to test the wrap, and checks that the link stays put even when the increment wraps. It rotates values with the link set and with it clear, so that a shift filling with zero, or a rotate that drops the link update, gives a wrong bit at the end. It loads the input port over a known high byte and watches for a clobbered upper half. It also runs idle cycles between operations, where a design that does not hold its value would drift.

// File: rtl/accum_pkg.sv
package accum_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned NUM_OPS = 9;

    // Per-stage source selects (AND-OR selection inside every bit slice)
    typedef struct packed {
        logic s_and;
        logic s_sum;
        logic s_opnd;
        logic s_port;
        logic s_inv;
        logic s_up;    // take neighbour above (rotate right)
        logic s_dn;    // take neighbour below (rotate left)
    } slice_sel_t;

    typedef enum logic [1:0] {
        LNK_HOLD  = 2'd0,
        LNK_CARRY = 2'd1,
        LNK_LSB   = 2'd2,
        LNK_MSB   = 2'd3
    } link_src_e;

    typedef struct packed {
        logic       load;
        logic       incr;
        logic       clear;
        link_src_e  link_src;
        slice_sel_t sel;
    } acc_ctl_t;

    function automatic logic slice_carry(input logic a, input logic b, input logic c);
        return (a & b) | (c & (a ^ b));
    endfunction

endpackage

// File: rtl/accum_ctrl.sv
module accum_ctrl
    import accum_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     s_and,
    input  logic     s_add,
    input  logic     s_load,
    input  logic     s_input,
    input  logic     s_comp,
    input  logic     s_shr,
    input  logic     s_shl,
    input  logic     s_clr,
    input  logic     s_inc,
    output acc_ctl_t ctl
);

    logic [NUM_OPS-1:0] strobes;
    assign strobes = {s_and, s_add, s_load, s_input, s_comp, s_shr, s_shl, s_clr, s_inc};

    always_comb begin
        ctl            = '0;
        ctl.sel.s_and  = s_and;
        ctl.sel.s_sum  = s_add;
        ctl.sel.s_opnd = s_load;
        ctl.sel.s_port = s_input;
        ctl.sel.s_inv  = s_comp;
        ctl.sel.s_up   = s_shr;
        ctl.sel.s_dn   = s_shl;
        ctl.load       = s_and | s_add | s_load | s_input | s_comp | s_shr | s_shl;
        ctl.incr       = s_inc;
        ctl.clear      = s_clr;
        if (s_add)      ctl.link_src = LNK_CARRY;
        else if (s_shr) ctl.link_src = LNK_LSB;
        else if (s_shl) ctl.link_src = LNK_MSB;
        else            ctl.link_src = LNK_HOLD;
    end

    // R12: the decoder upstream issues at most one strobe per cycle
    p_one_strobe_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobes));

    // R11/R12: exactly one register control per active strobe
    p_ctl_exclusive_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl.load, ctl.incr, ctl.clear}));

endmodule

// File: rtl/accum_slice.sv
module accum_slice
    import accum_pkg::*;
(
    input  slice_sel_t sel,
    input  logic       acc_b,
    input  logic       opnd_b,
    input  logic       port_b,
    input  logic       up_b,
    input  logic       dn_b,
    input  logic       cin,
    output logic       res_b,
    output logic       cout
);

    logic sum_b;

    always_comb begin
        sum_b = acc_b ^ opnd_b ^ cin;
        cout  = slice_carry(acc_b, opnd_b, cin);
        res_b = (sel.s_and  & acc_b & opnd_b)
              | (sel.s_sum  & sum_b)
              | (sel.s_opnd & opnd_b)
              | (sel.s_port & port_b)
              | (sel.s_inv  & ~acc_b)
              | (sel.s_up   & up_b)
              | (sel.s_dn   & dn_b);
    end

endmodule

// File: rtl/accum_unit.sv
module accum_unit
    import accum_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] data_in,
    input  logic [BYTE_W-1:0] port_in,
    input  logic              do_and,
    input  logic              do_add,
    input  logic              do_load,
    input  logic              do_input,
    input  logic              do_comp,
    input  logic              do_shr,
    input  logic              do_shl,
    input  logic              do_clr,
    input  logic              do_inc,
    output logic [WORD_W-1:0] acc_q,
    output logic              link_q
);

    localparam int unsigned HI_W = WORD_W - BYTE_W;

    acc_ctl_t ctl;

    logic [WORD_W-1:0] up_v;
    logic [WORD_W-1:0] dn_v;
    logic [WORD_W-1:0] port_v;
    logic [WORD_W-1:0] slice_res;
    logic [WORD_W:0]   carry;
    logic              link_nxt;

    accum_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .s_and   (do_and),
        .s_add   (do_add),
        .s_load  (do_load),
        .s_input (do_input),
        .s_comp  (do_comp),
        .s_shr   (do_shr),
        .s_shl   (do_shl),
        .s_clr   (do_clr),
        .s_inc   (do_inc),
        .ctl     (ctl)
    );

    // Neighbour wiring: the link bit closes both rotate rings
    assign up_v   = {link_q, acc_q[WORD_W-1:1]};
    assign dn_v   = {acc_q[WORD_W-2:0], link_q};
    // Upper slices re-select their own bit on a port load
    assign port_v = {acc_q[WORD_W-1:BYTE_W], port_in};
    assign carry[0] = 1'b0;

    for (genvar i = 0; i < WORD_W; i++) begin : g_slice
        accum_slice u_slice (
            .sel    (ctl.sel),
            .acc_b  (acc_q[i]),
            .opnd_b (data_in[i]),
            .port_b (port_v[i]),
            .up_b   (up_v[i]),
            .dn_b   (dn_v[i]),
            .cin    (carry[i]),
            .res_b  (slice_res[i]),
            .cout   (carry[i+1])
        );
    end

    always_comb begin
        unique case (ctl.link_src)
            LNK_CARRY: link_nxt = carry[WORD_W];
            LNK_LSB:   link_nxt = acc_q[0];
            LNK_MSB:   link_nxt = acc_q[WORD_W-1];
            default:   link_nxt = link_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.clear) acc_q <= '0;
        else if (ctl.incr)    acc_q <= acc_q + 1'b1;
        else if (ctl.load)    acc_q <= slice_res;
    end

    always_ff @(posedge clk) begin
        if (rst) link_q <= 1'b0;
        else     link_q <= link_nxt;
    end

    // ---------------- assertions ----------------
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (acc_q == '0) && !link_q);

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !(do_and | do_add | do_load | do_input | do_comp | do_shr | do_shl | do_clr | do_inc)
        |=> $stable(acc_q) && $stable(link_q));

    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        do_clr |=> (acc_q == '0) && $stable(link_q));

    p_inc_wrap_r10: assert property (@(posedge clk) disable iff (rst)
        do_inc |=> (acc_q == $past(acc_q) + 16'd1) && $stable(link_q));

    p_shr_link_r7: assert property (@(posedge clk) disable iff (rst)
        do_shr |=> (link_q == $past(acc_q[0])) && (acc_q[WORD_W-1] == $past(link_q)));

    p_shl_link_r8: assert property (@(posedge clk) disable iff (rst)
        do_shl |=> (link_q == $past(acc_q[WORD_W-1])) && (acc_q[0] == $past(link_q)));

    p_port_high_r5: assert property (@(posedge clk) disable iff (rst)
        do_input |=> $stable(acc_q[WORD_W-1 -: HI_W]) && $stable(link_q));

    p_add_sum_r3: assert property (@(posedge clk) disable iff (rst)
        do_add |=> ({link_q, acc_q} == {1'b0, $past(acc_q)} + {1'b0, $past(data_in)}));

endmodule

// File: tb/test_accum_unit.sv
module test_accum_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] data_in;
    logic [7:0]  port_in;
    logic [8:0]  stb;
    logic [15:0] acc_q;
    logic        link_q;

    // strobe bit positions used only inside the bench
    localparam int OP_AND = 0, OP_ADD = 1, OP_LOAD = 2, OP_INP = 3, OP_COMP = 4,
                   OP_SHR = 5, OP_SHL = 6, OP_CLR = 7, OP_INC = 8, OP_IDLE = 9;

    int tests = 0;
    int fails = 0;
    logic [15:0] m_acc;
    logic        m_link;

    always #5 clk = ~clk;

    accum_unit i_accum_unit (
        .clk(clk), .rst(rst), .data_in(data_in), .port_in(port_in),
        .do_and(stb[OP_AND]), .do_add(stb[OP_ADD]), .do_load(stb[OP_LOAD]),
        .do_input(stb[OP_INP]), .do_comp(stb[OP_COMP]), .do_shr(stb[OP_SHR]),
        .do_shl(stb[OP_SHL]), .do_clr(stb[OP_CLR]), .do_inc(stb[OP_INC]),
        .acc_q(acc_q), .link_q(link_q)
    );

    function automatic string req_of(input int op);
        case (op)
            OP_AND:  return "R2";
            OP_ADD:  return "R3";
            OP_LOAD: return "R4";
            OP_INP:  return "R5";
            OP_COMP: return "R6";
            OP_SHR:  return "R7";
            OP_SHL:  return "R8";
            OP_CLR:  return "R9";
            OP_INC:  return "R10";
            default: return "R11";
        endcase
    endfunction

    // reference model: returns {link, acc}
    function automatic logic [16:0] model(input int op, input logic [15:0] a,
                                          input logic l, input logic [15:0] d,
                                          input logic [7:0] p);
        logic [16:0] s;
        case (op)
            OP_AND:  return {l, a & d};
            OP_ADD:  begin s = {1'b0, a} + {1'b0, d}; return s; end
            OP_LOAD: return {l, d};
            OP_INP:  return {l, a[15:8], p};
            OP_COMP: return {l, ~a};
            OP_SHR:  return {a[0], l, a[15:1]};
            OP_SHL:  return {a[15], a[14:0], l};
            OP_CLR:  return {l, 16'h0000};
            OP_INC:  return {l, a + 16'd1};
            default: return {l, a};
        endcase
    endfunction

    task automatic check(input string req, input logic [16:0] got, input logic [16:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: link/acc got %0b/%04h expected %0b/%04h",
                     req, got[16], got[15:0], exp[16], exp[15:0]);
        end
    endtask

    // drive at negedge, result after one posedge (R12), sample at next negedge
    task automatic run_op(input int op, input logic [15:0] d, input logic [7:0] p);
        logic [16:0] e;
        data_in = d;
        port_in = p;
        stb     = '0;
        if (op != OP_IDLE) stb[op] = 1'b1;
        e = model(op, m_acc, m_link, d, p);
        @(negedge clk);
        stb = '0;
        {m_link, m_acc} = e;
        check(req_of(op), {link_q, acc_q}, e);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL R12: watchdog expired, got hang expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; stb = '0; data_in = '0; port_in = '0;
        @(negedge clk); @(negedge clk);
        check("R1", {link_q, acc_q}, 17'h0_0000);
        rst = 1'b0;
        m_acc = 16'h0000; m_link = 1'b0;

        // directed corners
        run_op(OP_LOAD, 16'hFFFF, 8'h00);   // R4
        run_op(OP_ADD,  16'h0001, 8'h00);   // R3 carry out -> link 1, acc 0
        run_op(OP_IDLE, 16'h1234, 8'h55);   // R11
        run_op(OP_INC,  16'h0000, 8'h00);   // R10
        run_op(OP_LOAD, 16'hFFFF, 8'h00);
        run_op(OP_INC,  16'h0000, 8'h00);   // R10 wrap, link stays 1
        run_op(OP_LOAD, 16'h8001, 8'h00);
        run_op(OP_SHR,  16'h0000, 8'h00);   // R7 link 1 enters bit15
        run_op(OP_SHL,  16'h0000, 8'h00);   // R8
        run_op(OP_CLR,  16'hFFFF, 8'hFF);   // R9
        run_op(OP_SHL,  16'h0000, 8'h00);   // R8 zero fill path
        run_op(OP_LOAD, 16'hA5C3, 8'h00);
        run_op(OP_INP,  16'h0000, 8'h7E);   // R5 high byte kept
        run_op(OP_COMP, 16'h0000, 8'h00);   // R6
        run_op(OP_AND,  16'h0FF0, 8'h00);   // R2
        run_op(OP_LOAD, 16'h7FFF, 8'h00);
        run_op(OP_ADD,  16'h8000, 8'h00);   // R3 sum exactly FFFF, no carry
        run_op(OP_IDLE, 16'h0000, 8'h00);

        for (int k = 0; k < 600; k++) begin
            int op;
            op = $urandom_range(0, 9);
            run_op(op, 16'($urandom()), 8'($urandom()));
        end

        // mid-run reset
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", {link_q, acc_q}, 17'h0_0000);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule